// File: doc/BRIEF.md
# Triggered Three-Axis Sample Queue

This block holds up to 32 three-axis samples. Each sample is one X, one Y and one Z word. A two-bit mode input picks one of four behaviours. Bypass keeps the queue empty. Queue mode fills until full and then refuses new samples. Ring mode overwrites the oldest sample when full. Capture mode runs as a ring until a trigger pulse arrives. The trigger then cuts the contents down to the newest `n` samples, where `n` is a programmable keep count. From that point the block fills like queue mode. After the cut, a settle window holds off reads for a fixed number of cycles, and an interrupt is raised on one of two outputs.

Samples enter through a write port with a valid strobe. The oldest sample is always visible on the read outputs, and a pop strobe removes it. A single trigger is taken per arming. To re-arm, set the mode to bypass and then back to capture. Because bypass clears the stored data, read the captured samples before re-arming.

Top module: `tri_axis_trig_fifo`

## Requirements
- R1: After reset, count_o is 0, rd_valid_o is 0, busy_o is 0, and irq_a_o and irq_b_o are both 0.
- R2: In queue mode (mode_i = 1), a write is stored only when count_o is below 32. Pops return samples in write order.
- R3: In ring mode (mode_i = 2), a write to a full queue stores the new sample and drops the oldest, so count_o stays at 32.
- R4: In bypass mode (mode_i = 0), count_o is 0 one cycle later, and writes in bypass are not stored.
- R5: In capture mode (mode_i = 3) before a trigger, the queue holds the newest 32 samples and drops the oldest on overflow.
- R6: A taken trigger keeps only the newest keep_n_i samples, counting any sample written in the same cycle. Older samples are discarded. If keep_n_i is at least the current count, nothing is dropped. A keep_n_i of 0 empties the queue.
- R7: After a trigger, capture mode stores writes only while count_o is below 32.
- R8: A trigger is taken only in capture mode while armed. Later triggers are ignored until the mode passes through bypass. Triggers in other modes are ignored.
- R9: A taken trigger sets irq_a_o when irq_sel_i is 0, or irq_b_o when irq_sel_i is 1, from the next cycle. The output stays high until bypass is entered. The two outputs are never high together.
- R10: For SETTLE (4) cycles after a taken trigger, busy_o is 1. During that window rd_valid_o is 0 and pops have no effect.
- R11: count_o reports 0 to 32 entries. rd_valid_o is 1 exactly when count_o is non-zero and busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 bypass, 1 queue, 2 ring, 3 capture |
| keep_n_i | input | 6 | Samples kept by a trigger |
| trig_i | input | 1 | Trigger pulse |
| irq_sel_i | input | 1 | Interrupt output select, latched at the trigger |
| wr_valid_i | input | 1 | Sample write strobe |
| wr_x_i | input | 16 | X word of incoming sample |
| wr_y_i | input | 16 | Y word of incoming sample |
| wr_z_i | input | 16 | Z word of incoming sample |
| pop_i | input | 1 | Remove the oldest sample |
| rd_valid_o | output | 1 | Oldest sample is readable |
| rd_x_o | output | 16 | X word of oldest sample |
| rd_y_o | output | 16 | Y word of oldest sample |
| rd_z_o | output | 16 | Z word of oldest sample |
| count_o | output | 6 | Stored entries |
| busy_o | output | 1 | Settle window after a trigger |
| irq_a_o | output | 1 | Trigger interrupt, select 0 |
| irq_b_o | output | 1 | Trigger interrupt, select 1 |

## Verification
The hardest state to reach is a trigger that lands on a ring that has already wrapped. In that state the read pointer sits mid-array, and a same-cycle write both overwrites and is counted in the cut.

The stimulus first overfills capture mode so that the write pointer wraps. It then fires the trigger together with a write. Next it refills the queue to full and pops every entry, which checks the pointer jump across the wrap.

Further runs trigger with a keep count above the current fill and with a keep count of 0. They also re-trigger without and then with a pass through bypass.

// File: rtl/tafifo_pkg.sv
package tafifo_pkg;
   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_QUEUE  = 2'd1,
      MODE_RING   = 2'd2,
      MODE_CAPT   = 2'd3
   } fifo_mode_e;
endpackage

// File: rtl/tafifo_store.sv
module tafifo_store #(
   parameter int AXIS_W = 16,
   parameter int DEPTH  = 32,
   parameter int N_AXIS = 3,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         we,
   input  logic [AW-1:0]                waddr,
   input  logic [N_AXIS-1:0][AXIS_W-1:0] wdata,
   input  logic [AW-1:0]                raddr,
   output logic [N_AXIS-1:0][AXIS_W-1:0] rdata
);
   // one storage array per axis word
   for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
      logic [AXIS_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we) mem[waddr] <= wdata[a];
      end
      assign rdata[a] = mem[raddr];
   end
endmodule

// File: rtl/tafifo_settle.sv
module tafifo_settle #(
   parameter int SETTLE = 4,
   localparam int SW    = $clog2(SETTLE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic load,
   output logic busy
);
   logic [SW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) left_q <= '0;
      else if (load)       left_q <= SW'(SETTLE);
      else if (left_q != '0) left_q <= left_q - 1'b1;
   end

   assign busy = (left_q != '0);
endmodule

// File: rtl/tafifo_ctrl.sv
module tafifo_ctrl
   import tafifo_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  fifo_mode_e    mode,
   input  logic          wr_valid,
   input  logic          pop,
   input  logic          trig,
   input  logic          irq_sel,
   input  logic [CW-1:0] keep_n,
   input  logic          busy,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output logic          armed,
   output logic          take,
   output logic          irq_a,
   output logic          irq_b
);
   logic [AW-1:0] rd_q, r0, r1;
   logic [CW-1:0] cnt_q, c0, c1, drop;
   logic          armed_q, irq_q, sel_q;
   logic          byp, pop_ok, ovw_mode, ovw;

   always_comb begin
      byp      = (mode == MODE_BYPASS);
      take     = trig && (mode == MODE_CAPT) && armed_q;
      pop_ok   = pop && (cnt_q != '0) && !busy && !take;
      c0       = cnt_q - CW'(pop_ok);
      r0       = rd_q + AW'(pop_ok);
      ovw_mode = (mode == MODE_RING) || ((mode == MODE_CAPT) && armed_q);
      wr_en    = wr_valid && !byp && (ovw_mode || (cnt_q != CW'(DEPTH)));
      ovw      = wr_en && (c0 == CW'(DEPTH));
      wr_addr  = r0 + AW'(c0);
      c1       = c0 + CW'(wr_en) - CW'(ovw);
      r1       = r0 + AW'(ovw);
      drop     = (take && (c1 > keep_n)) ? (c1 - keep_n) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || byp) begin
         rd_q    <= '0;
         cnt_q   <= '0;
         armed_q <= 1'b1;
         irq_q   <= 1'b0;
         sel_q   <= 1'b0;
      end else begin
         rd_q  <= r1 + AW'(drop);
         cnt_q <= c1 - drop;
         if (take) begin
            armed_q <= 1'b0;
            irq_q   <= 1'b1;
            sel_q   <= irq_sel;
         end
      end
   end

   assign rd_ptr = rd_q;
   assign count  = cnt_q;
   assign armed  = armed_q;
   assign irq_a  = irq_q && !sel_q;
   assign irq_b  = irq_q && sel_q;
endmodule

// File: rtl/tri_axis_trig_fifo.sv
module tri_axis_trig_fifo
   import tafifo_pkg::*;
#(
   parameter int AXIS_W = 16,
   parameter int DEPTH  = 32,
   parameter int SETTLE = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [CW-1:0]     keep_n_i,
   input  logic              trig_i,
   input  logic              irq_sel_i,
   input  logic              wr_valid_i,
   input  logic [AXIS_W-1:0] wr_x_i,
   input  logic [AXIS_W-1:0] wr_y_i,
   input  logic [AXIS_W-1:0] wr_z_i,
   input  logic              pop_i,
   output logic              rd_valid_o,
   output logic [AXIS_W-1:0] rd_x_o,
   output logic [AXIS_W-1:0] rd_y_o,
   output logic [AXIS_W-1:0] rd_z_o,
   output logic [CW-1:0]     count_o,
   output logic              busy_o,
   output logic              irq_a_o,
   output logic              irq_b_o
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end
   if (AXIS_W < 1) begin : g_bad_width
      $error("AXIS_W must be positive");
   end

   fifo_mode_e                 mode;
   logic                       wr_en, armed_w, take_w, busy_w;
   logic [AW-1:0]              wr_addr, rd_ptr;
   logic [2:0][AXIS_W-1:0]     wdata, rdata;

   assign mode  = fifo_mode_e'(mode_i);
   assign wdata = {wr_z_i, wr_y_i, wr_x_i};

   tafifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .mode(mode), .wr_valid(wr_valid_i),
      .pop(pop_i), .trig(trig_i), .irq_sel(irq_sel_i), .keep_n(keep_n_i),
      .busy(busy_w), .wr_en(wr_en), .wr_addr(wr_addr), .rd_ptr(rd_ptr),
      .count(count_o), .armed(armed_w), .take(take_w),
      .irq_a(irq_a_o), .irq_b(irq_b_o)
   );

   tafifo_settle #(.SETTLE(SETTLE)) u_settle (
      .clk(clk), .rst_n(rst_n), .clear(mode == MODE_BYPASS),
      .load(take_w), .busy(busy_w)
   );

   tafifo_store #(.AXIS_W(AXIS_W), .DEPTH(DEPTH), .N_AXIS(3)) u_store (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wdata),
      .raddr(rd_ptr), .rdata(rdata)
   );

   assign busy_o     = busy_w;
   assign rd_valid_o = (count_o != '0) && !busy_w;
   assign rd_x_o     = rdata[0];
   assign rd_y_o     = rdata[1];
   assign rd_z_o     = rdata[2];
endmodule

// File: rtl/tri_axis_trig_fifo_chk.sv
module tri_axis_trig_fifo_chk #(
   parameter int DEPTH = 32,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode_i,
   input logic [CW-1:0] keep_n_i,
   input logic          trig_i,
   input logic          wr_valid_i,
   input logic          pop_i,
   input logic [CW-1:0] count_o,
   input logic          rd_valid_o,
   input logic          busy_o,
   input logic          irq_a_o,
   input logic          irq_b_o,
   input logic          armed
);
   p_count_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CW'(DEPTH));

   p_queue_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd1 && count_o == CW'(DEPTH) && !pop_i) |=> count_o == CW'(DEPTH));

   p_ring_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd2 && count_o == CW'(DEPTH) && wr_valid_i && !pop_i)
      |=> count_o == CW'(DEPTH));

   p_bypass_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0) |=> count_o == '0);

   p_trim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && mode_i == 2'd3 && armed) |=> count_o <= $past(keep_n_i));

   p_irq_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_a_o, irq_b_o}));

   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_a_o || irq_b_o) && mode_i != 2'd0) |=> $stable({irq_a_o, irq_b_o}));

   p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !rd_valid_o);

   p_trig_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && mode_i == 2'd3 && armed) |=> !armed);
endmodule

bind tri_axis_trig_fifo tri_axis_trig_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .keep_n_i(keep_n_i),
   .trig_i(trig_i), .wr_valid_i(wr_valid_i), .pop_i(pop_i),
   .count_o(count_o), .rd_valid_o(rd_valid_o), .busy_o(busy_o),
   .irq_a_o(irq_a_o), .irq_b_o(irq_b_o), .armed(armed_w)
);

// File: tb/tri_axis_trig_fifo_tb.sv
module tri_axis_trig_fifo_tb;
   localparam int CLK_P  = 10;
   localparam int DEPTH  = 32;
   localparam int SETTLE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic [5:0]  keep_n_i = '0;
   logic        trig_i = 1'b0, irq_sel_i = 1'b0, wr_valid_i = 1'b0, pop_i = 1'b0;
   logic [15:0] wr_x_i = '0, wr_y_i = '0, wr_z_i = '0;
   logic        rd_valid_o, busy_o, irq_a_o, irq_b_o;
   logic [15:0] rd_x_o, rd_y_o, rd_z_o;
   logic [5:0]  count_o;

   always #(CLK_P/2) clk = ~clk;

   tri_axis_trig_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .keep_n_i(keep_n_i),
      .trig_i(trig_i), .irq_sel_i(irq_sel_i), .wr_valid_i(wr_valid_i),
      .wr_x_i(wr_x_i), .wr_y_i(wr_y_i), .wr_z_i(wr_z_i), .pop_i(pop_i),
      .rd_valid_o(rd_valid_o), .rd_x_o(rd_x_o), .rd_y_o(rd_y_o), .rd_z_o(rd_z_o),
      .count_o(count_o), .busy_o(busy_o), .irq_a_o(irq_a_o), .irq_b_o(irq_b_o)
   );

   int          total = 0, bad = 0;
   bit          done = 0, mon_on = 0;
   logic [47:0] exp_q[$];
   int          busy_m = 0;
   bit          armed_m = 1, irq_m = 0, sel_m = 0;
   int          seq = 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [47:0] mk(input int s);
      logic [15:0] x;
      x = 16'(s);
      return {x ^ 16'hA5A5, x + 16'h0100, x};
   endfunction

   // driver: one clock of stimulus, scoreboard updated at the edge
   task automatic cyc(input bit w, input bit p, input bit t, input int n, input bit s,
                      input string tag);
      bit take, pop_ok, ovw_mode;
      int pre;
      mode_i = 2'(mode_i);
      wr_valid_i = w; pop_i = p; trig_i = t; keep_n_i = 6'(n); irq_sel_i = s;
      {wr_z_i, wr_y_i, wr_x_i} = mk(seq);
      take   = t && mode_i == 2'd3 && armed_m;
      pop_ok = p && exp_q.size() > 0 && busy_m == 0 && !take;
      if (pop_ok) begin
         chk(rd_valid_o === 1'b1, {tag, " rd_valid"}, rd_valid_o, 1);
         chk({rd_z_o, rd_y_o, rd_x_o} === exp_q[0], {tag, " data"},
             {rd_z_o, rd_y_o, rd_x_o}, exp_q[0]);
      end
      @(posedge clk);
      if (mode_i == 2'd0) begin
         exp_q.delete(); armed_m = 1; irq_m = 0; sel_m = 0; busy_m = 0;
      end else begin
         pre = exp_q.size();
         ovw_mode = (mode_i == 2'd2) || (mode_i == 2'd3 && armed_m);
         if (pop_ok) void'(exp_q.pop_front());
         if (w && (ovw_mode || pre != DEPTH)) begin
            exp_q.push_back(mk(seq));
            if (exp_q.size() > DEPTH) void'(exp_q.pop_front());
         end
         if (take) begin
            while (exp_q.size() > n) void'(exp_q.pop_front());
            armed_m = 0; irq_m = 1; sel_m = s;
            busy_m = SETTLE;
         end else if (busy_m > 0) busy_m--;
      end
      if (w) seq++;
      @(negedge clk);
      wr_valid_i = 0; pop_i = 0; trig_i = 0;
   endtask

   // monitor: compares port state with the scoreboard between edges
   always @(negedge clk) begin
      if (mon_on) begin
         chk(count_o == 6'(exp_q.size()) && count_o <= 6'(DEPTH), "R11 count",
             count_o, exp_q.size());
         chk(rd_valid_o == (exp_q.size() > 0 && busy_m == 0), "R11/R10 rd_valid",
             rd_valid_o, (exp_q.size() > 0 && busy_m == 0));
         chk(busy_o == (busy_m > 0), "R10 busy", busy_o, busy_m > 0);
         chk(irq_a_o == (irq_m && !sel_m) && irq_b_o == (irq_m && sel_m), "R9 irq",
             {irq_a_o, irq_b_o}, {irq_m && !sel_m, irq_m && sel_m});
      end
   end

   task automatic set_mode(input logic [1:0] m);
      mode_i = m;
      cyc(0, 0, 0, 0, 0, "mode");
   endtask

   task automatic drain(input string tag);
      while (exp_q.size() > 0) cyc(0, 1, 0, 0, 0, tag);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         chk(0, "R1 watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(count_o == 0 && !rd_valid_o && !busy_o && !irq_a_o && !irq_b_o, "R1 reset",
          {count_o, rd_valid_o, busy_o, irq_a_o, irq_b_o}, 0);
      mon_on = 1;

      // R2: queue mode stops when full, order kept
      set_mode(2'd1);
      for (int i = 0; i < 35; i++) cyc(1, 0, 0, 0, 0, "R2 fill");
      chk(count_o == 32, "R2 full", count_o, 32);
      for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, "R2 pop");
      cyc(1, 1, 0, 0, 0, "R2 pop+write");

      // R4: bypass empties and ignores writes
      set_mode(2'd0);
      chk(count_o == 0, "R4 empty", count_o, 0);
      cyc(1, 0, 0, 0, 0, "R4 write");
      chk(count_o == 0, "R4 write ignored", count_o, 0);

      // R3: ring overwrites oldest
      set_mode(2'd2);
      for (int i = 0; i < 40; i++) cyc(1, 0, 0, 0, 0, "R3 fill");
      chk(count_o == 32, "R3 full", count_o, 32);
      for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, "R3 pop");
      cyc(1, 1, 0, 0, 0, "R3 pop+write");

      // R5/R6/R7/R9/R10: wrapped capture, trigger with write, keep 10 on irq_b
      set_mode(2'd0);
      set_mode(2'd3);
      for (int i = 0; i < 45; i++) cyc(1, 0, 0, 0, 0, "R5 fill");
      chk(count_o == 32, "R5 newest kept", count_o, 32);
      cyc(1, 0, 1, 10, 1, "R6 trigger");
      chk(count_o == 10, "R6 trim to n", count_o, 10);
      chk(irq_b_o && !irq_a_o, "R9 select b", {irq_a_o, irq_b_o}, 1);
      chk(busy_o && !rd_valid_o, "R10 busy", {busy_o, rd_valid_o}, 2);
      cyc(0, 1, 0, 0, 0, "R10 pop blocked");
      chk(count_o == 10, "R10 pop ignored", count_o, 10);
      repeat (SETTLE) cyc(0, 0, 0, 0, 0, "R10 settle");
      for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0, 0, "R7 fill");
      chk(count_o == 32, "R7 stop when full", count_o, 32);
      cyc(1, 0, 1, 2, 0, "R8 second trigger");
      chk(count_o == 32 && irq_b_o && !busy_o, "R8 ignored", count_o, 32);
      drain("R7 drain");

      // R6: n above fill keeps all, irq_a
      set_mode(2'd0);
      chk(!irq_a_o && !irq_b_o, "R9 cleared by bypass", {irq_a_o, irq_b_o}, 0);
      set_mode(2'd3);
      for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, "R6 fill");
      cyc(0, 0, 1, 20, 0, "R6 big n");
      chk(count_o == 5 && irq_a_o, "R6 keep all", count_o, 5);
      repeat (SETTLE) cyc(0, 0, 0, 0, 0, "R10 settle");
      drain("R6 drain");

      // R6: n of zero
      set_mode(2'd0);
      set_mode(2'd3);
      for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, "R6 fill0");
      cyc(0, 0, 1, 0, 0, "R6 zero n");
      chk(count_o == 0, "R6 keep none", count_o, 0);

      // R8: trigger outside capture mode ignored
      set_mode(2'd0);
      set_mode(2'd1);
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, "R8 fill");
      cyc(0, 0, 1, 0, 0, "R8 queue trigger");
      chk(count_o == 3 && !irq_a_o && !irq_b_o && !busy_o, "R8 not taken", count_o, 3);
      drain("R8 drain");

      done = 1;
      mon_on = 0;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule